// File: doc/BRIEF.md
# Dual-Channel Interval Timer

The block provides two independent counters behind one small register window. Each channel has a control/status word, a reload value and a live count. Software picks the count direction per channel, arms automatic reload, enables an interrupt on terminal count and presets the counter from the reload value. The interrupt output combines the pending and enabled events of both channels. A per-channel terminal-count flag is also brought out as a plain status pin.

Register access is a single-cycle write strobe with a combinational read. The port carries no stream data, so it has no valid/ready handshake. A write commits on the rising clock edge while `reg_we` is high. `reg_rdata` always reflects the word selected by `reg_addr`. Address bit 4 selects the channel, and bits 3:2 select the word: 0 is control/status, 1 is reload, 2 is count. The count word is read-only. Any other word, or a byte address that is not word aligned, reads zero and ignores writes. The capture, generate, PWM and mode-select bits are stored and read back but do not change counting.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset every register of both channels reads zero, the interrupt output is low and both status pins are low.
- R2: Per channel, word 0 is control, word 1 is reload and word 2 is the count. Channel 1 sits 0x10 above channel 0. Control bits read back as written, except bit 8, which reads the pending flag. The bits are: 0 mode select, 1 count down, 2 generate, 3 capture, 4 auto-reload, 5 preset, 6 interrupt enable, 7 run, 8 pending flag, 9 PWM, 10 run-both.
- R3: While the preset bit (5) is 1, each clock edge copies the reload value into the counter. Counting resumes on the edge after a control write that clears bit 5 and sets bit 7.
- R4: With bit 1 set the running counter decrements by one per clock; with bit 1 clear it increments by one.
- R5: A running counter at 0 (counting down) or at all-ones (counting up) reaches terminal count on the next edge. That edge sets the pending flag. With auto-reload (bit 4) set, it also loads the reload value into the counter.
- R6: On terminal count without auto-reload, the run bit clears and the counter holds its terminal value.
- R7: Writing 1 to bit 8 clears the pending flag, and writing 0 there leaves it alone. Writing back a value just read acknowledges the event and keeps all other bits. A terminal count on the same edge as a clearing write leaves the flag set.
- R8: The interrupt output is high exactly when some channel has its pending flag and its interrupt enable (bit 6) both set.
- R9: With bit 7 clear and bit 5 clear, the counter keeps its value, and the count word can be read at any time.
- R10: A control write with bit 10 set turns on the run bit of both channels on the same edge.
- R11: Bits 0, 2, 3 and 9 are held and read back but leave counting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Write strobe, commits on the rising edge |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Combined interrupt request |
| tc_flag | output | 2 | Pending terminal-count flag per channel |

## Verification
A wrong count or direction shows up in the count word on the very next read, because the counter moves one step per clock and the bench samples at exact cycle offsets. A fault in terminal detection or reload appears one edge after the counter reaches 0 or all-ones. It shows as a missing pending flag in the control word, a missing interrupt, or a count that fails to return to the reload value. A corrupted pending or run bit is visible at the control word and on `irq` in the same cycle. The collision case, a clearing write landing on a terminal edge, is timed to the exact edge.

// File: rtl/dit_pkg.sv
package dit_pkg;
  localparam int CTRL_W   = 11;
  localparam int B_MODE   = 0;
  localparam int B_DOWN   = 1;
  localparam int B_GEN    = 2;
  localparam int B_CAP    = 3;
  localparam int B_RELOAD = 4;
  localparam int B_PRESET = 5;
  localparam int B_IE     = 6;
  localparam int B_RUN    = 7;
  localparam int B_FLAG   = 8;
  localparam int B_PWM    = 9;
  localparam int B_BOTH   = 10;

  typedef enum logic [1:0] {
    WORD_CTRL = 2'd0,
    WORD_RELOAD = 2'd1,
    WORD_COUNT = 2'd2,
    WORD_NONE = 2'd3
  } word_e;
endpackage

// File: rtl/dit_channel.sv
module dit_channel
  import dit_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              rld_we,
  input  logic              both_run,
  input  logic [W-1:0]      wdata,
  output logic [CTRL_W-1:0] mode_q,
  output logic              flag_q,
  output logic [W-1:0]      reload_q,
  output logic [W-1:0]      cnt_q
);
  logic              at_end, running, term;
  logic [CTRL_W-1:0] mode_d;

  assign running = mode_q[B_RUN] & ~mode_q[B_PRESET];
  assign at_end  = mode_q[B_DOWN] ? (cnt_q == '0) : (cnt_q == '1);
  assign term    = running & at_end;

  always_comb begin
    mode_d = mode_q;
    if (ctl_we) begin
      mode_d = wdata[CTRL_W-1:0];
      mode_d[B_FLAG] = 1'b0;
      mode_d[B_RUN]  = wdata[B_RUN] | both_run;
    end else if (both_run) begin
      mode_d[B_RUN] = 1'b1;
    end else if (term && !mode_q[B_RELOAD]) begin
      mode_d[B_RUN] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      flag_q   <= 1'b0;
      reload_q <= '0;
      cnt_q    <= '0;
    end else begin
      mode_q <= mode_d;
      flag_q <= (flag_q & ~(ctl_we & wdata[B_FLAG])) | term;
      if (rld_we) reload_q <= wdata;
      if (mode_q[B_PRESET])    cnt_q <= reload_q;
      else if (term)           cnt_q <= mode_q[B_RELOAD] ? reload_q : cnt_q;
      else if (running)        cnt_q <= mode_q[B_DOWN] ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dit_regif.sv
module dit_regif
  import dit_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 32,
  localparam int AW  = $clog2(NCH) + 4,
  localparam int CHW = AW - 4
) (
  input  logic                        we,
  input  logic [AW-1:0]               addr,
  input  logic [W-1:0]                wdata,
  input  logic [NCH-1:0][CTRL_W-1:0]  mode_arr,
  input  logic [NCH-1:0]              flag_vec,
  input  logic [NCH-1:0][W-1:0]       reload_arr,
  input  logic [NCH-1:0][W-1:0]       cnt_arr,
  output logic [NCH-1:0]              ctl_we,
  output logic [NCH-1:0]              rld_we,
  output logic                        both_run,
  output logic [W-1:0]                rdata
);
  logic [CHW-1:0] ch;
  word_e          word;
  logic           hit;

  assign ch   = addr[AW-1:4];
  assign word = word_e'(addr[3:2]);
  assign hit  = (addr[1:0] == 2'b00) && (int'(ch) < NCH);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign ctl_we[i] = we && hit && ch == CHW'(i) && word == WORD_CTRL;
    assign rld_we[i] = we && hit && ch == CHW'(i) && word == WORD_RELOAD;
  end

  assign both_run = (|ctl_we) & wdata[B_BOTH];

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit && ch == CHW'(i)) begin
        unique case (word)
          WORD_CTRL: begin
            rdata[CTRL_W-1:0] = mode_arr[i];
            rdata[B_FLAG]     = flag_vec[i];
          end
          WORD_RELOAD: rdata = reload_arr[i];
          WORD_COUNT:  rdata = cnt_arr[i];
          default:     rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dit_pkg::*;
#(
  parameter int NCH = 2,
  parameter int W   = 32,
  localparam int AW = $clog2(NCH) + 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  output logic           irq,
  output logic [NCH-1:0] tc_flag
);
  logic [NCH-1:0][CTRL_W-1:0] mode_arr;
  logic [NCH-1:0][W-1:0]      reload_arr, cnt_arr;
  logic [NCH-1:0]             flag_vec, ctl_we, rld_we, ie_vec, run_vec, pre_vec;
  logic                       both_run;

  dit_regif #(.NCH(NCH), .W(W)) regif_i (
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mode_arr(mode_arr), .flag_vec(flag_vec), .reload_arr(reload_arr),
    .cnt_arr(cnt_arr), .ctl_we(ctl_we), .rld_we(rld_we),
    .both_run(both_run), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dit_channel #(.W(W)) ch_i (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we[i]), .rld_we(rld_we[i]),
      .both_run(both_run), .wdata(reg_wdata), .mode_q(mode_arr[i]),
      .flag_q(flag_vec[i]), .reload_q(reload_arr[i]), .cnt_q(cnt_arr[i])
    );
    assign ie_vec[i]  = mode_arr[i][B_IE];
    assign run_vec[i] = mode_arr[i][B_RUN];
    assign pre_vec[i] = mode_arr[i][B_PRESET];
  end

  assign irq     = |(flag_vec & ie_vec);
  assign tc_flag = flag_vec;
endmodule

// File: rtl/dit_chk.sv
module dit_chk #(
  parameter int NCH = 2,
  parameter int W   = 32,
  localparam int AW  = $clog2(NCH) + 4,
  localparam int CHW = AW - 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_we,
  input logic [AW-1:0]         reg_addr,
  input logic [W-1:0]          reg_wdata,
  input logic                  irq,
  input logic [NCH-1:0]        tc_flag,
  input logic [NCH-1:0]        run_vec,
  input logic [NCH-1:0]        pre_vec,
  input logic [NCH-1:0][W-1:0] cnt_arr,
  input logic [NCH-1:0][W-1:0] reload_arr
);
  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_we));

  for (genvar i = 0; i < NCH; i++) begin : g_c
    // R5
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_flag[i]) |-> $past(run_vec[i] && !pre_vec[i] &&
                                  (cnt_arr[i] == '0 || cnt_arr[i] == '1)));
    // R7
    flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_flag[i]) |-> $past(reg_we && reg_addr[AW-1:4] == CHW'(i) &&
                                  reg_addr[3:0] == 4'h0 && reg_wdata[8]));
    // R3
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_vec[i] |=> cnt_arr[i] == $past(reload_arr[i]));
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_vec[i] && !pre_vec[i]) |=> $stable(cnt_arr[i]));
    // R6
    run_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_vec[i]) |-> $past(reg_we || cnt_arr[i] == '0 || cnt_arr[i] == '1));
  end
endmodule

bind dual_interval_timer dit_chk #(.NCH(NCH), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .tc_flag(tc_flag), .run_vec(run_vec),
  .pre_vec(pre_vec), .cnt_arr(cnt_arr), .reload_arr(reload_arr)
);

// File: tb/dual_interval_timer_tb_top.sv
module dual_interval_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [1:0]  tc_flag;
  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  dual_interval_timer dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .tc_flag(tc_flag)
  );

  // op: 0 idle, 1 write, 2 read and compare {rdata, irq}
  localparam int NV = 28;
  localparam logic [39:0] VEC [0:NV-1] = '{
    {2'd1, 5'h04, 32'h0000_0005, 1'b0},  // R2 reload ch0
    {2'd1, 5'h00, 32'h0000_0020, 1'b0},  // R3 preset on
    {2'd2, 5'h00, 32'h0000_0020, 1'b0},  // R2 readback
    {2'd2, 5'h08, 32'h0000_0005, 1'b0},  // R3 forced value
    {2'd1, 5'h00, 32'h0000_00D2, 1'b0},  // run, down, reload, ie
    {2'd2, 5'h08, 32'h0000_0005, 1'b0},  // R3 still preset on that edge
    {2'd2, 5'h08, 32'h0000_0004, 1'b0},  // R4 down step
    {2'd0, 5'h00, 32'h0, 1'b0},
    {2'd0, 5'h00, 32'h0, 1'b0},
    {2'd0, 5'h00, 32'h0, 1'b0},
    {2'd2, 5'h08, 32'h0000_0000, 1'b0},  // R4 reached zero
    {2'd2, 5'h00, 32'h0000_01D2, 1'b1},  // R5 R8 flag and irq
    {2'd2, 5'h08, 32'h0000_0004, 1'b1},  // R5 reloaded then stepped
    {2'd1, 5'h00, 32'h0000_01D2, 1'b0},  // R7 write-back ack
    {2'd1, 5'h00, 32'h0000_0052, 1'b0},  // stop
    {2'd2, 5'h08, 32'h0000_0001, 1'b0},  // R9 R8 value at stop, irq low
    {2'd0, 5'h00, 32'h0, 1'b0},
    {2'd2, 5'h08, 32'h0000_0001, 1'b0},  // R9 held
    {2'd2, 5'h00, 32'h0000_0052, 1'b0},  // R7 mode kept, flag clear
    {2'd1, 5'h14, 32'hFFFF_FFFD, 1'b0},  // R2 reload ch1
    {2'd1, 5'h10, 32'h0000_0020, 1'b0},
    {2'd0, 5'h00, 32'h0, 1'b0},
    {2'd1, 5'h10, 32'h0000_0080, 1'b0},  // run up, no reload
    {2'd2, 5'h18, 32'hFFFF_FFFD, 1'b0},
    {2'd2, 5'h18, 32'hFFFF_FFFE, 1'b0},  // R4 up step
    {2'd2, 5'h18, 32'hFFFF_FFFF, 1'b0},
    {2'd2, 5'h10, 32'h0000_0100, 1'b0},  // R6 run cleared, flag set, ie off
    {2'd2, 5'h18, 32'hFFFF_FFFF, 1'b0}   // R6 held at terminal
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got=running exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    foreach (VEC[k]) begin end
    for (int a = 0; a < 2; a++) begin
      for (int w = 0; w < 3; w++) begin
        rd(5'(a * 16 + w * 4), v);
        chk("R1", v, 32'h0);
      end
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 tc_flag", {30'b0, tc_flag}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      reg_addr = VEC[k][37:33];
      reg_wdata = VEC[k][32:1];
      reg_we = (VEC[k][39:38] == 2'd1);
      #1;
      if (VEC[k][39:38] == 2'd2) begin
        chk($sformatf("R2-R9 vec%0d rdata", k), reg_rdata, VEC[k][32:1]);
        chk($sformatf("R8 vec%0d irq", k), {31'b0, irq}, {31'b0, VEC[k][0]});
      end
      @(negedge clk);
      reg_we = 1'b0;
    end
    chk("R6 tc_flag", {30'b0, tc_flag}, 32'h2);

    // R7 clearing write on the terminal edge, then a zero write
    do_reset();
    wr(5'h04, 32'd2);
    wr(5'h00, 32'h20);
    @(negedge clk);
    wr(5'h00, 32'hD2);
    repeat (2) @(negedge clk);
    wr(5'h00, 32'h1D2);
    rd(5'h00, v);
    chk("R7 collision", v, 32'h1D2);
    chk("R8 irq", {31'b0, irq}, 32'h1);
    wr(5'h00, 32'hD2);
    rd(5'h00, v);
    chk("R7 zero write", v, 32'h1D2);

    // R10 run-both
    do_reset();
    wr(5'h00, 32'h400);
    rd(5'h00, v);
    chk("R10 ch0", v, 32'h480);
    rd(5'h10, v);
    chk("R10 ch1", v, 32'h080);

    // R11 inert bits, then R9 hold
    do_reset();
    wr(5'h14, 32'h100);
    wr(5'h10, 32'h20);
    @(negedge clk);
    wr(5'h10, 32'h28D);
    rd(5'h10, v);
    chk("R11 readback", v, 32'h28D);
    rd(5'h18, v);
    chk("R11 count", v, 32'h101);
    rd(5'h18, v);
    chk("R11 count", v, 32'h102);
    wr(5'h10, 32'h20D);
    repeat (3) @(negedge clk);
    rd(5'h18, v);
    chk("R9 hold", v, 32'h104);
    rd(5'h1C, v);
    chk("R2 unused word", v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule